// File: doc/BRIEF.md
# RAM Page Write Guard with Keyed Erase Unlock

This block sits beside a small on-chip RAM that is split into 32 pages of 1 KiB each. It keeps a 32-bit protection mask, with one bit per page, and checks every RAM write request against that mask. A write to a protected page is held back and reported with a one-cycle violation pulse. A write to an unprotected page is passed on. Software can set mask bits through a simple register bus, but it can never clear them. Only a system reset clears the mask.

The same register bus also reaches a configuration register whose bit 0 requests an erase of the RAM. That bit is normally locked. To reach it, software writes two values in order to a write-only key register: first 0xCA, then 0x53. The unlock then lasts for exactly one write to the configuration register. If a wrong key arrives, or if any other register is written first, the block locks again. When an erase request is accepted, the block sends a single-cycle start pulse to the erase engine.

The register bus has no read strobe. Read data is registered from the address presented in the previous cycle. The RAM results are also registered, so they appear one cycle after the request.

Top module: `ram_page_guard`

## Requirements
- R1: After a synchronous reset, the mask and the configuration register read as 0x00000000, and `ram_pass`, `ram_violation` and `erase_start` are 0.
- R2: A write to offset 0x20 sets every mask bit whose write-data bit is 1. Write-data bits that are 0 leave their mask bits unchanged, so a mask bit, once set, stays set until reset.
- R3: The key register at offset 0x24 is write-only and reads as 0, and so does every unmapped offset. All reads appear on `reg_rdata` one cycle after the address is presented.
- R4: After key writes of 0xCA and then 0x53 to offset 0x24, a write to the configuration register at offset 0x18 is accepted. Its bit 0 becomes the erase-request bit that is read back at offset 0x18.
- R5: A key write that is not the expected next value (0xCA from the locked state, 0x53 after 0xCA) returns the block to the locked state. This includes a repeated 0xCA or a 0x53 sent alone. While locked, a write to offset 0x18 has no effect.
- R6: An unlock serves one configuration write only. A second configuration write that is not preceded by a fresh key sequence has no effect.
- R7: A write to any register other than the key register, made between the last key and the configuration write, cancels the unlock.
- R8: A RAM write request whose page, taken from `ram_addr[14:10]`, has its mask bit set gives `ram_pass`=0 and `ram_violation`=1 in the next cycle. A request to an unprotected page gives `ram_pass`=1 and `ram_violation`=0.
- R9: A RAM request made in the same cycle as a mask write is judged against the mask as it stood before that cycle. The new protection applies from the following cycle.
- R10: An accepted configuration write with bit 0 set produces an `erase_start` pulse in the next cycle, and that pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Registered read data for the previous cycle's offset |
| ram_req | input | 1 | RAM write request |
| ram_addr | input | 15 | RAM byte address of the request |
| ram_pass | output | 1 | Request forwarded to the RAM (registered) |
| ram_violation | output | 1 | One-cycle pulse for a blocked request |
| erase_start | output | 1 | One-cycle erase start pulse |

## Verification
The key sequencer is driven with the correct pair and also with wrong orders: 0x53 alone, 0xCA repeated, and 0x53 repeated. It is also driven with the correct pair followed by a mask write, and with a second configuration write after an accepted one. These patterns separate the states "expecting the first key", "expecting the second key" and "open for one write", and they show that the unlock is spent after one use. RAM requests go to pages 0, 1, 3, 4 and 31, with both protected and unprotected pages. This exercises the decoding of the page field. One request is made in the same cycle as the mask write that protects its page, which shows which mask value the guard uses.

// File: rtl/page_guard_pkg.sv
package page_guard_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 32;
  localparam logic [REG_AW-1:0] OFS_CFG  = 8'h18;
  localparam logic [REG_AW-1:0] OFS_MASK = 8'h20;
  localparam logic [REG_AW-1:0] OFS_KEY  = 8'h24;
  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;
endpackage

// File: rtl/key_sequencer.sv
module key_sequencer
  import page_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        key_data,
  output logic              unlocked
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (reg_we) begin
      if (reg_addr == OFS_KEY) begin
        if (state_q == KS_HALF && key_data == KEY_SECOND)
          state_d = KS_OPEN;
        else if (state_q != KS_HALF && key_data == KEY_FIRST)
          state_d = KS_HALF;
        else
          state_d = KS_LOCKED;
      end else begin
        state_d = KS_LOCKED;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= KS_LOCKED;
    else     state_q <= state_d;
  end

  assign unlocked = (state_q == KS_OPEN);
endmodule

// File: rtl/protect_mask.sv
module protect_mask #(
  parameter int PAGES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [PAGES-1:0] set_bits,
  output logic [PAGES-1:0] mask
);
  for (genvar i = 0; i < PAGES; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                      mask[i] <= 1'b0;
      else if (set_en && set_bits[i]) mask[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/ram_write_filter.sv
module ram_write_filter #(
  parameter int PAGES      = 32,
  parameter int PAGE_LSB   = 10,
  parameter int RAM_AW     = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGES-1:0]  mask,
  input  logic              ram_req,
  input  logic [RAM_AW-1:0] ram_addr,
  output logic              ram_pass,
  output logic              ram_violation
);
  localparam int PAGE_W = $clog2(PAGES);

  logic [PAGE_W-1:0] page;
  logic              hit;

  assign page = ram_addr[PAGE_LSB +: PAGE_W];
  assign hit  = mask[page];

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_pass      <= 1'b0;
      ram_violation <= 1'b0;
    end else begin
      ram_pass      <= ram_req && !hit;
      ram_violation <= ram_req && hit;
    end
  end
endmodule

// File: rtl/ram_page_guard.sv
module ram_page_guard
  import page_guard_pkg::*;
#(
  parameter int PAGES    = 32,
  parameter int PAGE_LSB = 10,
  parameter int RAM_AW   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              ram_req,
  input  logic [RAM_AW-1:0] ram_addr,
  output logic              ram_pass,
  output logic              ram_violation,
  output logic              erase_start
);
  logic [PAGES-1:0] mask_q;
  logic             unlocked;
  logic             cfg_q;
  logic             cfg_accept;
  logic             mask_wr;

  assign mask_wr    = reg_we && (reg_addr == OFS_MASK);
  assign cfg_accept = reg_we && (reg_addr == OFS_CFG) && unlocked;

  key_sequencer u_keys (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .key_data (reg_wdata[7:0]),
    .unlocked (unlocked)
  );

  protect_mask #(.PAGES(PAGES)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .set_en   (mask_wr),
    .set_bits (reg_wdata[PAGES-1:0]),
    .mask     (mask_q)
  );

  ram_write_filter #(
    .PAGES(PAGES), .PAGE_LSB(PAGE_LSB), .RAM_AW(RAM_AW)
  ) u_filter (
    .clk           (clk),
    .rst           (rst),
    .mask          (mask_q),
    .ram_req       (ram_req),
    .ram_addr      (ram_addr),
    .ram_pass      (ram_pass),
    .ram_violation (ram_violation)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      erase_start <= cfg_accept && reg_wdata[0];
      if (cfg_accept) cfg_q <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      if (reg_addr == OFS_CFG)  reg_rdata[0] <= cfg_q;
      if (reg_addr == OFS_MASK) reg_rdata[PAGES-1:0] <= mask_q;
    end
  end
endmodule

// File: rtl/page_guard_checker.sv
module page_guard_checker
  import page_guard_pkg::*;
#(
  parameter int PAGES  = 32,
  parameter int RAM_AW = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_wdata,
  input logic              reg_we,
  input logic [REG_DW-1:0] reg_rdata,
  input logic              ram_req,
  input logic              ram_pass,
  input logic              ram_violation,
  input logic              erase_start,
  input logic [PAGES-1:0]  mask_q
);
  // R1: reset clears the outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (reg_rdata == '0 && !erase_start && !ram_pass && !ram_violation));

  // R2: a mask bit never falls while out of reset
  assert_mask_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (($past(mask_q) & ~mask_q) == '0));

  // R3: the key register reads as zero
  assert_key_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    $past(reg_addr == OFS_KEY) |-> (reg_rdata == '0));

  // R4: an erase pulse needs a configuration write with bit 0 set
  assert_erase_cause_R4: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> $past(reg_we && reg_addr == OFS_CFG && reg_wdata[0]));

  // R8: a violation needs a request, and the request is not also passed
  assert_violation_cause_R8: assert property (@(posedge clk) disable iff (rst)
    ram_violation |-> ($past(ram_req) && !ram_pass));

  // R8: nothing comes out without a request
  assert_no_spurious_pass_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(ram_req) |-> (!ram_pass && !ram_violation));

  // R10: the erase pulse lasts one cycle
  assert_erase_single_R10: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start);
endmodule

bind ram_page_guard page_guard_checker #(.PAGES(PAGES), .RAM_AW(RAM_AW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .reg_we        (reg_we),
  .reg_rdata     (reg_rdata),
  .ram_req       (ram_req),
  .ram_pass      (ram_pass),
  .ram_violation (ram_violation),
  .erase_start   (erase_start),
  .mask_q        (mask_q)
);

// File: tb/test_ram_page_guard.sv
`timescale 1ns/1ps
module test_ram_page_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        ram_req = 1'b0;
  logic [14:0] ram_addr = '0;
  logic        ram_pass, ram_violation, erase_start;

  int checks = 0;
  int failures = 0;

  // reference model state
  logic [31:0] m_mask = '0;
  int          m_key = 0;   // 0 locked, 1 first key seen, 2 open
  logic        m_cfg = 1'b0;

  always #4 clk = ~clk;

  ram_page_guard i_ram_page_guard (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .ram_req(ram_req),
    .ram_addr(ram_addr), .ram_pass(ram_pass), .ram_violation(ram_violation),
    .erase_start(erase_start)
  );

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: apply inputs, predict, advance, compare.
  task automatic step(string tag, logic [7:0] a, logic [31:0] d, logic we,
                      logic rq, logic [14:0] ra);
    logic [31:0] e_rd;
    logic        e_pass, e_viol, e_er;
    int          pg;
    reg_addr = a; reg_wdata = d; reg_we = we; ram_req = rq; ram_addr = ra;
    pg = int'(ra) / 1024;
    if (a == 8'h18)      e_rd = {31'd0, m_cfg};
    else if (a == 8'h20) e_rd = m_mask;
    else                 e_rd = 32'd0;
    e_pass = rq && (m_mask[pg] == 1'b0);
    e_viol = rq && (m_mask[pg] == 1'b1);
    e_er   = we && a == 8'h18 && m_key == 2 && d[0];
    if (we) begin
      if (a == 8'h18 && m_key == 2) m_cfg = d[0];
      if (a == 8'h20) m_mask = m_mask | d;
      if (a == 8'h24) begin
        if (m_key == 1 && d[7:0] == 8'h53)      m_key = 2;
        else if (m_key != 1 && d[7:0] == 8'hCA) m_key = 1;
        else                                     m_key = 0;
      end else m_key = 0;
    end
    @(posedge clk); #1;
    cmp(tag, "rdata", reg_rdata, e_rd);
    cmp(tag, "pass", {31'd0, ram_pass}, {31'd0, e_pass});
    cmp(tag, "violation", {31'd0, ram_violation}, {31'd0, e_viol});
    cmp(tag, "erase_start", {31'd0, erase_start}, {31'd0, e_er});
  endtask

  task automatic rd(string tag, logic [7:0] a);
    step(tag, a, 32'd0, 1'b0, 1'b0, 15'd0);
  endtask
  task automatic wr(string tag, logic [7:0] a, logic [31:0] d);
    step(tag, a, d, 1'b1, 1'b0, 15'd0);
  endtask
  task automatic ram(string tag, int page, int ofs);
    step(tag, 8'h00, 32'd0, 1'b0, 1'b1, 15'(page * 1024 + ofs));
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    cmp("R1", "rdata", reg_rdata, 32'd0);
    cmp("R1", "erase_start", {31'd0, erase_start}, 32'd0);
    rd("R1", 8'h20);
    rd("R1", 8'h18);
    // R2 set-only mask
    wr("R2", 8'h20, 32'h8000_0005);
    rd("R2", 8'h20);
    wr("R2", 8'h20, 32'h0000_0010);
    wr("R2", 8'h20, 32'h0000_0000);
    rd("R2", 8'h20);
    rd("R2", 8'h20);
    // R3 key and unmapped read as zero
    wr("R3", 8'h24, 32'h0000_00CA);
    rd("R3", 8'h24);
    rd("R3", 8'h04);
    rd("R3", 8'h18);
    // R8 page decode
    ram("R8", 0, 12);
    ram("R8", 1, 1023);
    ram("R8", 31, 500);
    ram("R8", 4, 0);
    ram("R8", 3, 7);
    ram("R8", 2, 0);
    // R9 same-cycle mask write uses old mask
    step("R9", 8'h20, 32'h0000_0008, 1'b1, 1'b1, 15'(3 * 1024 + 4));
    ram("R9", 3, 4);
    // R4 / R10 unlock and erase
    wr("R4", 8'h24, 32'hCA);
    wr("R4", 8'h24, 32'h53);
    wr("R10", 8'h18, 32'h1);
    rd("R10", 8'h18);
    rd("R4", 8'h18);
    // R6 unlock spent
    wr("R6", 8'h18, 32'h0);
    rd("R6", 8'h18);
    wr("R4", 8'h24, 32'hCA);
    wr("R4", 8'h24, 32'h53);
    wr("R4", 8'h18, 32'h0);
    rd("R4", 8'h18);
    // R5 wrong orders
    wr("R5", 8'h24, 32'hCA);
    wr("R5", 8'h24, 32'hCA);
    wr("R5", 8'h24, 32'h53);
    wr("R5", 8'h18, 32'h1);
    rd("R5", 8'h18);
    wr("R5", 8'h24, 32'h53);
    wr("R5", 8'h18, 32'h1);
    rd("R5", 8'h18);
    wr("R5", 8'h24, 32'hCA);
    wr("R5", 8'h24, 32'h53);
    wr("R5", 8'h24, 32'h53);
    wr("R5", 8'h18, 32'h1);
    rd("R5", 8'h18);
    wr("R5", 8'h24, 32'hCA);
    wr("R5", 8'h24, 32'h12);
    wr("R5", 8'h24, 32'h53);
    wr("R5", 8'h18, 32'h1);
    rd("R5", 8'h18);
    // R7 other register write cancels unlock
    wr("R7", 8'h24, 32'hCA);
    wr("R7", 8'h24, 32'h53);
    wr("R7", 8'h20, 32'h0);
    wr("R7", 8'h18, 32'h1);
    rd("R7", 8'h18);
    // R7 control: a fresh sequence still works afterwards
    wr("R7", 8'h24, 32'hCA);
    wr("R7", 8'h24, 32'h53);
    wr("R10", 8'h18, 32'h1);
    rd("R10", 8'h18);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule